// File: doc/BRIEF.md
# Secure Real-Time Counter Register Block

This block is a memory-mapped time keeper with a 32-bit register interface. It holds a whole-seconds count and a 15-bit sub-second count. Each pulse on the `tick` input stands in for one cycle of a slow oscillator and advances the sub-second count. When the sub-second count wraps, the seconds count advances by one. The combined count is compared against a two-word alarm. A set of sticky status flags, gated by interrupt enables, drives a single interrupt line.

The bus accepts every register write at once, but the new value takes effect only after a short, fixed commit delay. A small state machine runs this delay. It has two states: `ST_IDLE`, in which the block is ready for a write, and `ST_BUSY`, which holds the captured write for `COMMIT_LAT` cycles. The transition `ST_IDLE -> ST_BUSY` happens when a write is accepted. The transition `ST_BUSY -> ST_IDLE` is the commit, which applies the write and raises the completion flag. A write that arrives during `ST_BUSY` is discarded and raises the error flag. Software polls the completion and error flags after each write.

The counter does not advance until three conditions all hold: the seconds register has been written since reset, the invalid state has been left, and the enable bit is set.

Top module: `rtc_secure_regs`

## Requirements
- R1: After reset the registers read as follows: seconds 0, sub-second 0, alarm high word 0xFFFFFFFF, alarm low word 0, control 0, status 0x00000202 (invalid bit 1 and ready bit 9), interrupt enable 0. The `irq` output is 0.
- R2: Word index selects the register: 0 seconds, 1 sub-second, 2 alarm high, 3 alarm low, 4 control, 5 status, 6 interrupt enable. Index 7 reads 0.
- R3: A write accepted in `ST_IDLE` sets status bit 10 (busy) and clears bit 9 (ready) for exactly `COMMIT_LAT` = 4 cycles. After those cycles the target register holds the new value and status bit 8 (complete) is set. Bit 8 clears when the next write is accepted.
- R4: A write presented while busy is dropped and sets status bit 7 (error). The write already in flight still commits.
- R5: A committed write to status clears bit 7 or bit 4 (alarm) wherever the written data has a 1 in that position. If a set event for a flag occurs in the same cycle as its clear, the flag stays set.
- R6: Status bit 1 (invalid) is set by reset. It is cleared only by a committed status write whose data has bits 1 and 0 both set. Writing bit 1 alone leaves it set.
- R7: Ticks advance the count only when all of these hold: control bit 3 (enable) is set, the seconds register has been written since reset, and status bit 1 is clear. Otherwise the count holds.
- R8: The 15-bit sub-second count wraps from 0x7FFF to 0 and carries one into the seconds count.
- R9: Status bit 4 sets when {seconds, sub-second} becomes equal to {alarm high, alarm low[14:0]}.
- R10: `irq` is the OR, over bits 9, 8, 7 and 4, of a status bit and the interrupt-enable bit in the same position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Sub-second advance strobe |
| wr_en | input | 1 | Register write request |
| word_addr | input | 3 | Register word index (read and write) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `word_addr` |
| irq | output | 1 | Interrupt request |

## Verification
A state machine stuck in `ST_BUSY`, or leaving it early, shows in the status word within the four-cycle window. The busy and ready bits stop toggling, or the complete bit appears at the wrong cycle. A wrong count-gating state shows up one tick later as a sub-second value that moves when it should hold, or holds when it should move. Lost flag priority appears at the next status read or as a wrong level on `irq` in the cycle after the event. A mis-decoded alarm word leaves bit 4 clear on the tick that should set it.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned IDX_W   = 3;

    localparam logic [IDX_W-1:0] IDX_SEC    = 3'd0;
    localparam logic [IDX_W-1:0] IDX_FRAC   = 3'd1;
    localparam logic [IDX_W-1:0] IDX_ALM_HI = 3'd2;
    localparam logic [IDX_W-1:0] IDX_ALM_LO = 3'd3;
    localparam logic [IDX_W-1:0] IDX_CTRL   = 3'd4;
    localparam logic [IDX_W-1:0] IDX_STAT   = 3'd5;
    localparam logic [IDX_W-1:0] IDX_IEN    = 3'd6;

    localparam int unsigned B_RUN  = 3;
    localparam int unsigned B_BUSY = 10;
    localparam int unsigned B_RDY  = 9;
    localparam int unsigned B_DONE = 8;
    localparam int unsigned B_ERR  = 7;
    localparam int unsigned B_ALM  = 4;
    localparam int unsigned B_INV  = 1;
    localparam int unsigned B_SEC  = 0;

    localparam logic [DATA_W-1:0] IEN_MASK =
        (DATA_W'(1) << B_RDY) | (DATA_W'(1) << B_DONE) |
        (DATA_W'(1) << B_ERR) | (DATA_W'(1) << B_ALM);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } commit_state_e;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } wr_req_t;
endpackage

// File: rtl/rtc_commit_fsm.sv
module rtc_commit_fsm
    import rtc_pkg::*;
#(
    parameter int unsigned LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              accept,
    output logic              commit,
    output logic              collide,
    output wr_req_t           cmt_req
);
    localparam int unsigned CNT_W = (LAT > 2) ? $clog2(LAT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LAT - 1);

    commit_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    wr_req_t          req_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (wr_en) state_d = ST_BUSY;
            ST_BUSY: if (cnt_q == CNT_LAST) state_d = ST_IDLE;
        endcase
    end

    // state register and captured write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            req_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cnt_q <= '0;
                req_q <= '{idx: wr_idx, data: wr_data};
            end else if (state_q == ST_BUSY) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        busy    = 1'b0;
        accept  = 1'b0;
        commit  = 1'b0;
        collide = 1'b0;
        unique case (state_q)
            ST_IDLE: accept = wr_en;
            ST_BUSY: begin
                busy    = 1'b1;
                collide = wr_en;
                commit  = (cnt_q == CNT_LAST);
            end
        endcase
    end

    assign cmt_req = req_q;
endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
    import rtc_pkg::*;
#(
    parameter int unsigned FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              ld_sec,
    input  logic              ld_frac,
    input  logic [DATA_W-1:0] ld_data,
    output logic [DATA_W-1:0] sec_q,
    output logic [FRAC_W-1:0] frac_q
);
    localparam logic [FRAC_W-1:0] FRAC_TOP = {FRAC_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q  <= '0;
            frac_q <= '0;
        end else begin
            if (ld_sec) begin
                sec_q <= ld_data;
            end else if (advance && frac_q == FRAC_TOP) begin
                sec_q <= sec_q + DATA_W'(1);
            end
            if (ld_frac) begin
                frac_q <= ld_data[FRAC_W-1:0];
            end else if (advance) begin
                frac_q <= frac_q + FRAC_W'(1);
            end
        end
    end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_pkg::*;
#(
    parameter int unsigned FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sec,
    input  logic [FRAC_W-1:0] frac,
    input  logic [DATA_W-1:0] alm_hi,
    input  logic [FRAC_W-1:0] alm_lo,
    output logic              hit
);
    logic match, match_q;

    assign match = (sec == alm_hi) && (frac == alm_lo);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= match;
    end

    assign hit = match && !match_q;
endmodule

// File: rtl/rtc_secure_regs.sv
module rtc_secure_regs
    import rtc_pkg::*;
#(
    parameter int unsigned FRAC_W     = 15,
    parameter int unsigned COMMIT_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  word_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic    busy, accept, commit, collide, hit, advance;
    wr_req_t cmt_req;
    logic [DATA_W-1:0] sec_q, alm_hi_q, ien_q, stat_vec;
    logic [FRAC_W-1:0] frac_q, alm_lo_q;
    logic run_q, done_q, err_q, alm_q, inv_q, sec_written_q;
    logic ld_sec, ld_frac, st_wr;

    rtc_commit_fsm #(.LAT(COMMIT_LAT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(word_addr),
        .wr_data(wdata), .busy(busy), .accept(accept), .commit(commit),
        .collide(collide), .cmt_req(cmt_req)
    );

    assign ld_sec  = commit && (cmt_req.idx == IDX_SEC);
    assign ld_frac = commit && (cmt_req.idx == IDX_FRAC);
    assign st_wr   = commit && (cmt_req.idx == IDX_STAT);
    assign advance = tick && run_q && sec_written_q && !inv_q;

    rtc_time_counter #(.FRAC_W(FRAC_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .advance(advance), .ld_sec(ld_sec),
        .ld_frac(ld_frac), .ld_data(cmt_req.data), .sec_q(sec_q),
        .frac_q(frac_q)
    );

    rtc_alarm_cmp #(.FRAC_W(FRAC_W)) u_alm (
        .clk(clk), .rst_n(rst_n), .sec(sec_q), .frac(frac_q),
        .alm_hi(alm_hi_q), .alm_lo(alm_lo_q), .hit(hit)
    );

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alm_hi_q      <= '1;
            alm_lo_q      <= '0;
            run_q         <= 1'b0;
            ien_q         <= '0;
            sec_written_q <= 1'b0;
        end else if (commit) begin
            unique case (cmt_req.idx)
                IDX_ALM_HI: alm_hi_q <= cmt_req.data;
                IDX_ALM_LO: alm_lo_q <= cmt_req.data[FRAC_W-1:0];
                IDX_CTRL:   run_q    <= cmt_req.data[B_RUN];
                IDX_IEN:    ien_q    <= cmt_req.data & IEN_MASK;
                IDX_SEC:    sec_written_q <= 1'b1;
                default: ;
            endcase
        end
    end

    // status flags: set events take priority over clears
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            alm_q  <= 1'b0;
            inv_q  <= 1'b1;
        end else begin
            if (commit)      done_q <= 1'b1;
            else if (accept) done_q <= 1'b0;

            if (collide)                          err_q <= 1'b1;
            else if (st_wr && cmt_req.data[B_ERR]) err_q <= 1'b0;

            if (hit)                              alm_q <= 1'b1;
            else if (st_wr && cmt_req.data[B_ALM]) alm_q <= 1'b0;

            if (st_wr && cmt_req.data[B_INV] && cmt_req.data[B_SEC])
                inv_q <= 1'b0;
        end
    end

    always_comb begin
        stat_vec         = '0;
        stat_vec[B_BUSY] = busy;
        stat_vec[B_RDY]  = !busy;
        stat_vec[B_DONE] = done_q;
        stat_vec[B_ERR]  = err_q;
        stat_vec[B_ALM]  = alm_q;
        stat_vec[B_INV]  = inv_q;
    end

    assign irq = |(stat_vec & ien_q);

    always_comb begin
        rdata = '0;
        case (word_addr)
            IDX_SEC:    rdata = sec_q;
            IDX_FRAC:   rdata = DATA_W'(frac_q);
            IDX_ALM_HI: rdata = alm_hi_q;
            IDX_ALM_LO: rdata = DATA_W'(alm_lo_q);
            IDX_CTRL:   rdata = DATA_W'(run_q) << B_RUN;
            IDX_STAT:   rdata = stat_vec;
            IDX_IEN:    rdata = ien_q;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtc_secure_regs_chk.sv
module rtc_secure_regs_chk
    import rtc_pkg::*;
#(
    parameter int unsigned FRAC_W = 15,
    parameter int unsigned LAT    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              busy,
    input logic              commit,
    input logic              done_q,
    input logic              err_q,
    input logic              inv_q,
    input logic              run_q,
    input logic [DATA_W-1:0] sec_q,
    input logic [FRAC_W-1:0] frac_q
);
    logic [7:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + 8'd1;
        else           busy_run <= '0;
    end

    a_r3_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < 8'(LAT)));

    a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_q);

    a_r4_collision_error: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> err_q);

    a_r6_frozen_while_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_q && !commit) |=> $stable({sec_q, frac_q}));

    a_r7_hold_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !commit) |=> $stable({sec_q, frac_q}));
endmodule

bind rtc_secure_regs rtc_secure_regs_chk #(.FRAC_W(FRAC_W), .LAT(COMMIT_LAT)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy), .commit(commit),
    .done_q(done_q), .err_q(err_q), .inv_q(inv_q), .run_q(run_q),
    .sec_q(sec_q), .frac_q(frac_q)
);

// File: tb/test_rtc_secure_regs.sv
module test_rtc_secure_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  word_addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [31:0] S_BUSY = 32'h400, S_RDY = 32'h200, S_DONE = 32'h100;
    localparam logic [31:0] S_ERR = 32'h80, S_ALM = 32'h10, S_INV = 32'h2;

    // {word index, expected reset value}
    localparam logic [34:0] RESET_TBL [8] = '{
        {3'd0, 32'h0000_0000}, {3'd1, 32'h0000_0000},
        {3'd2, 32'hFFFF_FFFF}, {3'd3, 32'h0000_0000},
        {3'd4, 32'h0000_0000}, {3'd5, 32'h0000_0202},
        {3'd6, 32'h0000_0000}, {3'd7, 32'h0000_0000}
    };

    always #2 clk = ~clk;

    rtc_secure_regs i_rtc_secure_regs (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .word_addr(word_addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] val);
        word_addr = idx;
        #1;
        val = rdata;
    endtask

    // ends at the falling edge just after acceptance (busy visible)
    task automatic start_write(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; word_addr = idx; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic write_wait(input logic [2:0] idx, input logic [31:0] d);
        start_write(idx, d);
        repeat (4) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2: reset values through the address map
        for (int i = 0; i < 8; i++) begin
            rd(RESET_TBL[i][34:32], v);
            check("R1/R2 reset map", v, RESET_TBL[i][31:0]);
        end
        check("R1 irq at reset", {31'd0, irq}, 32'd0);

        // R3: commit handshake timing
        start_write(3'd4, 32'h8);
        rd(3'd5, v);
        check("R3 busy set, ready clear", v & (S_BUSY | S_RDY), S_BUSY);
        repeat (3) @(negedge clk);
        rd(3'd5, v);
        check("R3 busy on fourth cycle", v & S_BUSY, S_BUSY);
        @(negedge clk);
        rd(3'd5, v);
        check("R3 complete after commit", v & (S_BUSY | S_RDY | S_DONE), S_RDY | S_DONE);
        rd(3'd4, v);
        check("R3 control committed", v, 32'h8);

        // R7: invalid state blocks counting
        ticks(5);
        rd(3'd1, v);
        check("R7 frozen while invalid", v, 32'd0);

        // R6: invalid cleared only with both bits
        write_wait(3'd5, 32'h2);
        rd(3'd5, v);
        check("R6 single bit keeps invalid", v & S_INV, S_INV);
        write_wait(3'd5, 32'h3);
        rd(3'd5, v);
        check("R6 both bits clear invalid", v & S_INV, 32'd0);

        // R7: seconds never written
        ticks(5);
        rd(3'd1, v);
        check("R7 frozen before seconds write", v, 32'd0);
        write_wait(3'd0, 32'd100);
        ticks(5);
        rd(3'd1, v);
        check("R7 counts after seconds write", v, 32'd5);
        rd(3'd0, v);
        check("R7 seconds held", v, 32'd100);

        // R7: enable bit clear holds
        write_wait(3'd4, 32'h0);
        ticks(3);
        rd(3'd1, v);
        check("R7 hold when disabled", v, 32'd5);
        write_wait(3'd4, 32'h8);

        // R8 / R9: wrap and alarm
        write_wait(3'd1, 32'h7FFE);
        write_wait(3'd2, 32'd101);
        write_wait(3'd3, 32'd1);
        rd(3'd5, v);
        check("R9 alarm not yet", v & S_ALM, 32'd0);
        ticks(3);
        rd(3'd0, v);
        check("R8 carry into seconds", v, 32'd101);
        rd(3'd1, v);
        check("R8 sub-second wrapped", v, 32'd1);
        rd(3'd5, v);
        check("R9 alarm flag set", v & S_ALM, S_ALM);

        // R10 / R5: alarm interrupt and clear
        check("R10 masked irq", {31'd0, irq}, 32'd0);
        write_wait(3'd6, 32'h10);
        check("R10 alarm irq", {31'd0, irq}, 32'd1);
        write_wait(3'd5, 32'h10);
        rd(3'd5, v);
        check("R5 alarm cleared", v & S_ALM, 32'd0);
        check("R5 irq dropped", {31'd0, irq}, 32'd0);

        // R4: collision
        @(negedge clk);
        wr_en = 1'b1; word_addr = 3'd4; wdata = 32'h8;
        @(negedge clk);
        word_addr = 3'd6; wdata = 32'h390;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (4) @(negedge clk);
        rd(3'd5, v);
        check("R4 error flag", v & (S_ERR | S_DONE), S_ERR | S_DONE);
        rd(3'd6, v);
        check("R4 dropped write", v, 32'h10);
        rd(3'd4, v);
        check("R4 first write kept", v, 32'h8);

        // R10 / R5: error interrupt and clear
        write_wait(3'd6, 32'h80);
        check("R10 error irq", {31'd0, irq}, 32'd1);
        write_wait(3'd5, 32'h80);
        rd(3'd5, v);
        check("R5 error cleared", v & S_ERR, 32'd0);
        check("R5 irq after clear", {31'd0, irq}, 32'd0);

        // R10: ready interrupt follows busy
        write_wait(3'd6, 32'h200);
        check("R10 ready irq idle", {31'd0, irq}, 32'd1);
        start_write(3'd4, 32'h8);
        check("R10 ready irq busy", {31'd0, irq}, 32'd0);
        repeat (4) @(negedge clk);
        check("R10 ready irq back", {31'd0, irq}, 32'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule